// File: doc/BRIEF.md
# Transmit slew-rate calibration sequencer

This block works out the high-speed transmit slew-rate setting of a serial link transmitter. It turns on an on-chip ring oscillator and lets it settle. It then counts how many reference-clock cycles the oscillator takes to complete a programmed number of its own cycles. That count becomes a 3-bit code through a multi-cycle integer divider. The whole block runs on the reference clock. The oscillator arrives as an asynchronous toggling level and is resynchronized inside the block.

Software or a power-up controller supplies three values: the reference frequency in MHz, a scaling coefficient and an optional forced code. It then pulses `start`. A nonzero forced code bypasses the measurement entirely. Otherwise the block runs the full enable, measure, compute and write sequence. It then reports completion with a one-cycle pulse, and a sticky flag shows whether the meter timed out.

Top module: `srcal_seq`

## Requirements
- R1: After reset `code_o` is 0, and `done_o`, `timeout_o` and `osc_en_o` are all low.
- R2: If `force_code_i` is nonzero when a start is accepted, the block never raises `osc_en_o`. It sets `code_o` to that value and then pulses `done_o`.
- R3: A measured run follows this order: raise `osc_en_o`, wait `SETTLE_US` microseconds, enable the free-running count clock, load the cycle target, enable the meter. Afterwards the meter is disabled before the count clock, and `code_o` is updated while `osc_en_o` is still high. `osc_en_o` falls in the cycle `done_o` is raised.
- R4: The meter counts reference cycles from its enable until the resynchronized oscillator has shown `CYCLE_CNT` rising edges. It then raises valid and holds the count until it is disabled.
- R5: The meter's valid flag is sampled once every `POLL_US` microseconds. If it is still low at the sample that completes `TIMEOUT_US`, `timeout_o` is set and the sequence continues with the count present, which is 0.
- R6: For a nonzero count N, the code is round-half-up(floor(ref × coef × `CYCLE_CNT` / N) / `DIVISOR`). Both divisions use a restoring shift-subtract divider.
- R7: A count of 0 gives code 3, and no division by zero is started.
- R8: A code result above 7 is written as 7.
- R9: A start that arrives while a sequence is running is ignored. Each accepted start produces exactly one `done_o` pulse, one cycle long.
- R10: `timeout_o` is cleared when a start is accepted and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a calibration run |
| ref_mhz_i | input | REF_W | Reference frequency in MHz, latched at start |
| coef_i | input | COEF_W | Scaling coefficient, latched at start |
| force_code_i | input | 3 | Nonzero value bypasses measurement |
| osc_clk_i | input | 1 | Ring-oscillator output, asynchronous |
| osc_en_o | output | 1 | Ring-oscillator enable |
| code_o | output | 3 | Slew-rate code |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Meter never became valid in the last run |

## Verification
The bench builds the block with `TICKS_PER_US = 4` and `CYCLE_CNT = 16`. The settle wait therefore takes four cycles, and a full 200 µs timeout finishes in about 800 cycles. With these values, an oscillator period of a few cycles is enough to drive the code anywhere from 1 up to the saturated value of 7. Because the measured count depends on the synchronizer phase, the bench computes the code over a small window of counts. The chosen ref, coef and period points give a single code across that window, and the 5 case only comes out right when the result is rounded rather than truncated.

// File: rtl/srcal_pkg.sv
package srcal_pkg;

    localparam int CODE_W = 3;
    localparam logic [CODE_W-1:0] FAIL_CODE = 3'd3;
    localparam logic [CODE_W-1:0] CODE_MAX  = 3'd7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_FRCK_ON,
        S_LOAD,
        S_MTR_ON,
        S_POLL,
        S_READ,
        S_MTR_OFF,
        S_FRCK_OFF,
        S_DIV1,
        S_DIV2,
        S_WRITE,
        S_OSC_OFF
    } srcal_state_e;

endpackage

// File: rtl/srcal_us_tick.sv
module srcal_us_tick #(
    parameter int TICKS_PER_US = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int TW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [TW-1:0] LAST = TW'(TICKS_PER_US - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en_i || cnt_q == LAST) cnt_d = '0;
        else                        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == LAST);

    generate
        if (TICKS_PER_US > 1) begin : g_spacing
            // R5: microsecond ticks never come back to back
            a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/srcal_fmeter.sv
module srcal_fmeter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_clk_i,
    input  logic             frck_en_i,
    input  logic             fm_en_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             valid_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] edges;
        logic [CNT_W-1:0] ref_cnt;
        logic             valid;
        logic [CNT_W-1:0] count;
    } fm_t;

    fm_t fm_d, fm_q;
    logic             rise;
    logic [CNT_W-1:0] ref_nx;

    assign rise   = fm_q.sync[1] & ~fm_q.sync[2];
    assign ref_nx = (&fm_q.ref_cnt) ? fm_q.ref_cnt : fm_q.ref_cnt + 1'b1;

    always_comb begin
        fm_d      = fm_q;
        fm_d.sync = {fm_q.sync[1:0], osc_clk_i};
        if (!fm_en_i) begin
            fm_d.edges   = '0;
            fm_d.ref_cnt = '0;
            fm_d.valid   = 1'b0;
            fm_d.count   = '0;
        end else if (!fm_q.valid) begin
            fm_d.ref_cnt = ref_nx;
            if (frck_en_i && rise) begin
                fm_d.edges = fm_q.edges + 1'b1;
                if (fm_q.edges + 1'b1 == target_i) begin
                    fm_d.valid = 1'b1;
                    fm_d.count = ref_nx;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fm_q <= '0;
        else        fm_q <= fm_d;
    end

    assign valid_o = fm_q.valid;
    assign count_o = fm_q.count;

    // R4: once valid, the count holds until the meter is disabled
    a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_en_i && valid_o) |=> (!fm_en_i || (valid_o && $stable(count_o))));

    // R4: a valid measurement always spans at least one reference cycle
    a_r4_valid_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (count_o != '0));

endmodule

// File: rtl/srcal_div.sv
module srcal_div #(
    parameter int DW = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_i,
    input  logic [DW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic          done_o,
    output logic [DW-1:0] quo_o
);
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [DW:0]   rem;
        logic [DW-1:0] quo;
        logic [DW-1:0] den;
        logic [DW-1:0] num;
    } dv_t;

    dv_t dv_d, dv_q;
    logic [DW:0] trial;

    assign trial = {dv_q.rem[DW-1:0], dv_q.quo[DW-1]};

    always_comb begin
        dv_d      = dv_q;
        dv_d.done = 1'b0;
        if (dv_q.busy) begin
            if (trial >= {1'b0, dv_q.den}) begin
                dv_d.rem = trial - {1'b0, dv_q.den};
                dv_d.quo = {dv_q.quo[DW-2:0], 1'b1};
            end else begin
                dv_d.rem = trial;
                dv_d.quo = {dv_q.quo[DW-2:0], 1'b0};
            end
            dv_d.cnt = dv_q.cnt - 1'b1;
            if (dv_q.cnt == CW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.done = 1'b1;
            end
        end else if (go_i) begin
            dv_d.busy = 1'b1;
            dv_d.cnt  = CW'(DW);
            dv_d.rem  = '0;
            dv_d.quo  = num_i;
            dv_d.den  = den_i;
            dv_d.num  = num_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dv_q <= '0;
        else        dv_q <= dv_d;
    end

    assign done_o = dv_q.done;
    assign quo_o  = dv_q.quo;

    logic [2*DW-1:0] chk_prod;
    always_comb chk_prod = (2*DW)'(dv_q.quo) * (2*DW)'(dv_q.den);

    // R6: quotient and remainder reconstruct the dividend on completion
    a_r6_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((chk_prod + (2*DW)'(dv_q.rem) == (2*DW)'(dv_q.num))
                    && (dv_q.rem < {1'b0, dv_q.den})));

    // R7: the divider is never started with a zero divisor
    a_r7_no_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !dv_q.busy) |-> (den_i != '0));

endmodule

// File: rtl/srcal_seq.sv
module srcal_seq
    import srcal_pkg::*;
#(
    parameter int REF_W        = 8,
    parameter int COEF_W       = 8,
    parameter int CNT_W        = 24,
    parameter int CYCLE_CNT    = 1024,
    parameter int TICKS_PER_US = 26,
    parameter int SETTLE_US    = 1,
    parameter int POLL_US      = 10,
    parameter int TIMEOUT_US   = 200,
    parameter int DIVISOR      = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REF_W-1:0]  ref_mhz_i,
    input  logic [COEF_W-1:0] coef_i,
    input  logic [2:0]        force_code_i,
    input  logic              osc_clk_i,
    output logic              osc_en_o,
    output logic [2:0]        code_o,
    output logic              done_o,
    output logic              timeout_o
);
    localparam int CC_W   = $clog2(CYCLE_CNT + 1);
    localparam int PROD_W = REF_W + COEF_W + CC_W;
    localparam int DW     = ((PROD_W > CNT_W) ? PROD_W : CNT_W) + 1;
    localparam int US_MAX = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
    localparam int US_W   = $clog2(US_MAX + 1);
    localparam int NPOLL  = (TIMEOUT_US / POLL_US > 0) ? TIMEOUT_US / POLL_US : 1;
    localparam int PW     = $clog2(NPOLL + 1);

    typedef struct packed {
        srcal_state_e      state;
        logic [US_W-1:0]   us;
        logic [PW-1:0]     polls;
        logic              osc_en;
        logic              frck_en;
        logic              fm_en;
        logic [CNT_W-1:0]  cyc;
        logic [CNT_W-1:0]  cnt;
        logic [REF_W-1:0]  refm;
        logic [COEF_W-1:0] coef;
        logic [2:0]        pend;
        logic [2:0]        code;
        logic              done;
        logic              tmo;
        logic              div_go;
        logic [DW-1:0]     div_num;
        logic [DW-1:0]     div_den;
    } sq_t;

    sq_t sq_d, sq_q;

    logic             tick;
    logic             tick_en;
    logic             mtr_valid;
    logic [CNT_W-1:0] mtr_count;
    logic             div_done;
    logic [DW-1:0]    div_quo;
    logic [DW-1:0]    prod;

    assign tick_en = (sq_q.state == S_SETTLE) || (sq_q.state == S_POLL);
    assign prod    = DW'(sq_q.refm) * DW'(sq_q.coef) * DW'(CYCLE_CNT);

    srcal_us_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .tick_o (tick)
    );

    srcal_fmeter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_clk_i (osc_clk_i),
        .frck_en_i (sq_q.frck_en),
        .fm_en_i   (sq_q.fm_en),
        .target_i  (sq_q.cyc),
        .valid_o   (mtr_valid),
        .count_o   (mtr_count)
    );

    srcal_div #(.DW(DW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (sq_q.div_go),
        .num_i  (sq_q.div_num),
        .den_i  (sq_q.div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    always_comb begin
        sq_d        = sq_q;
        sq_d.done   = 1'b0;
        sq_d.div_go = 1'b0;
        unique case (sq_q.state)
            S_IDLE: begin
                if (start_i) begin
                    sq_d.tmo  = 1'b0;
                    sq_d.refm = ref_mhz_i;
                    sq_d.coef = coef_i;
                    if (force_code_i != 3'd0) begin
                        sq_d.pend  = force_code_i;
                        sq_d.state = S_WRITE;
                    end else begin
                        sq_d.osc_en = 1'b1;
                        sq_d.us     = '0;
                        sq_d.state  = S_SETTLE;
                    end
                end
            end
            S_SETTLE: begin
                if (tick) begin
                    if (sq_q.us == US_W'(SETTLE_US - 1)) sq_d.state = S_FRCK_ON;
                    else                                 sq_d.us    = sq_q.us + 1'b1;
                end
            end
            S_FRCK_ON: begin
                sq_d.frck_en = 1'b1;
                sq_d.state   = S_LOAD;
            end
            S_LOAD: begin
                sq_d.cyc   = CNT_W'(CYCLE_CNT);
                sq_d.state = S_MTR_ON;
            end
            S_MTR_ON: begin
                sq_d.fm_en = 1'b1;
                sq_d.us    = '0;
                sq_d.polls = '0;
                sq_d.state = S_POLL;
            end
            S_POLL: begin
                if (tick) begin
                    if (sq_q.us == US_W'(POLL_US - 1)) begin
                        sq_d.us = '0;
                        if (mtr_valid) begin
                            sq_d.state = S_READ;
                        end else if (sq_q.polls == PW'(NPOLL - 1)) begin
                            sq_d.tmo   = 1'b1;
                            sq_d.state = S_READ;
                        end else begin
                            sq_d.polls = sq_q.polls + 1'b1;
                        end
                    end else begin
                        sq_d.us = sq_q.us + 1'b1;
                    end
                end
            end
            S_READ: begin
                sq_d.cnt   = mtr_count;
                sq_d.state = S_MTR_OFF;
            end
            S_MTR_OFF: begin
                sq_d.fm_en = 1'b0;
                sq_d.state = S_FRCK_OFF;
            end
            S_FRCK_OFF: begin
                sq_d.frck_en = 1'b0;
                if (sq_q.cnt == '0) begin
                    sq_d.pend  = FAIL_CODE;
                    sq_d.state = S_WRITE;
                end else begin
                    sq_d.div_go  = 1'b1;
                    sq_d.div_num = prod;
                    sq_d.div_den = DW'(sq_q.cnt);
                    sq_d.state   = S_DIV1;
                end
            end
            S_DIV1: begin
                if (div_done) begin
                    sq_d.div_go  = 1'b1;
                    sq_d.div_num = div_quo + DW'(DIVISOR / 2);
                    sq_d.div_den = DW'(DIVISOR);
                    sq_d.state   = S_DIV2;
                end
            end
            S_DIV2: begin
                if (div_done) begin
                    sq_d.pend  = (div_quo > DW'(CODE_MAX)) ? CODE_MAX : div_quo[2:0];
                    sq_d.state = S_WRITE;
                end
            end
            S_WRITE: begin
                sq_d.code  = sq_q.pend;
                sq_d.state = S_OSC_OFF;
            end
            S_OSC_OFF: begin
                sq_d.osc_en = 1'b0;
                sq_d.done   = 1'b1;
                sq_d.state  = S_IDLE;
            end
            default: sq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign osc_en_o  = sq_q.osc_en;
    assign code_o    = sq_q.code;
    assign done_o    = sq_q.done;
    assign timeout_o = sq_q.tmo;

    // R3: the meter only runs while the count clock is enabled
    a_r3_meter_needs_frck: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.fm_en |-> sq_q.frck_en);

    // R3: the count clock only runs while the oscillator is enabled
    a_r3_frck_needs_osc: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.frck_en |-> osc_en_o);

    // R3: a code update is followed by the completion pulse
    a_r3_code_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |=> done_o);

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a timeout is only declared while the meter had no valid result
    a_r5_timeout_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !$past(mtr_valid));

endmodule

// File: tb/sim_srcal_seq.sv
module sim_srcal_seq;

    localparam int TICKS = 4;
    localparam int CYC   = 16;
    localparam int LIMIT = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] ref_mhz_i = '0;
    logic [7:0] coef_i = '0;
    logic [2:0] force_code_i = '0;
    logic       osc_clk_i = 1'b0;
    logic       osc_en_o;
    logic [2:0] code_o;
    logic       done_o;
    logic       timeout_o;

    always #10 clk = ~clk;

    srcal_seq #(
        .CYCLE_CNT    (CYC),
        .TICKS_PER_US (TICKS)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .ref_mhz_i    (ref_mhz_i),
        .coef_i       (coef_i),
        .force_code_i (force_code_i),
        .osc_clk_i    (osc_clk_i),
        .osc_en_o     (osc_en_o),
        .code_o       (code_o),
        .done_o       (done_o),
        .timeout_o    (timeout_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    bit busy_m = 0;
    bit pend_force = 0;
    int pend_lo, pend_hi;
    bit pend_to = 0;
    int exp_code = 0;
    bit exp_to = 0;
    bit saw_chg_osc = 0;
    int osc_hi_cnt = 0;
    bit done_seen = 0;
    string to_req = "R5";

    int osc_half = 0;
    int osc_ph = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int code_for(input int num, input int c);
        int q, r;
        if (c == 0) return 3;
        q = num / c;
        r = (q + 500) / 1000;
        return (r > 7) ? 7 : r;
    endfunction

    // ring oscillator model: runs only while enabled by the block
    always @(negedge clk) begin
        if (osc_half > 0 && osc_en_o) begin
            osc_ph++;
            if (osc_ph >= osc_half) begin
                osc_clk_i = ~osc_clk_i;
                osc_ph = 0;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (busy_m) begin
                if (osc_en_o) osc_hi_cnt++;
                if (osc_en_o && int'(code_o) != exp_code) saw_chg_osc = 1;
                if (pend_force) chk(!osc_en_o, "R2 osc_en during forced run", osc_en_o, 0);
                if (done_o) begin
                    chk(int'(code_o) >= pend_lo && int'(code_o) <= pend_hi,
                        "R6 code at done", code_o, pend_lo);
                    chk(timeout_o == pend_to, to_req, timeout_o, pend_to);
                    chk(!osc_en_o, "R3 osc_en low with done", osc_en_o, 0);
                    exp_code = code_o;
                    exp_to = pend_to;
                    busy_m = 0;
                    done_seen = 1;
                end
            end else begin
                chk(int'(code_o) == exp_code, "R10 idle code hold", code_o, exp_code);
                chk(timeout_o == exp_to, "R10 idle timeout hold", timeout_o, exp_to);
                chk(!done_o, "R9 no spurious done", done_o, 0);
                chk(!osc_en_o, "R3 osc_en idle", osc_en_o, 0);
            end
        end
    end

    task automatic run(input int frc, input int refm, input int coef, input int per,
                       input bit inject, input bit exp_tmo, input string treq);
        int num, prev, n;
        num = refm * coef * CYC;
        prev = exp_code;
        if (frc != 0) begin
            pend_lo = frc; pend_hi = frc;
        end else if (per == 0) begin
            pend_lo = 3; pend_hi = 3;
        end else begin
            pend_lo = 7; pend_hi = 0;
            for (int c = (CYC - 1) * per - 3; c <= CYC * per + 6; c++) begin
                if (code_for(num, c) < pend_lo) pend_lo = code_for(num, c);
                if (code_for(num, c) > pend_hi) pend_hi = code_for(num, c);
            end
        end
        @(posedge clk); #1;
        osc_half = per / 2;
        ref_mhz_i = refm[7:0];
        coef_i = coef[7:0];
        force_code_i = frc[2:0];
        pend_force = (frc != 0);
        pend_to = exp_tmo;
        to_req = treq;
        saw_chg_osc = 0;
        osc_hi_cnt = 0;
        done_seen = 0;
        busy_m = 1;
        start_i = 1;
        @(posedge clk); #1;
        start_i = 0;
        if (inject) begin
            repeat (20) @(posedge clk);
            #1;
            force_code_i = 3'd2;
            start_i = 1;
            @(posedge clk); #1;
            start_i = 0;
        end
        n = 0;
        while (!done_seen && n < LIMIT) begin
            @(posedge clk);
            n++;
        end
        chk(done_seen, "R9 run completes", done_seen, 1);
        if (frc != 0) begin
            chk(osc_hi_cnt == 0, "R2 oscillator never enabled", osc_hi_cnt, 0);
        end else begin
            chk(osc_hi_cnt >= TICKS, "R3 oscillator settle time", osc_hi_cnt, TICKS);
            if (exp_code != prev)
                chk(saw_chg_osc, "R3 code written before osc off", saw_chg_osc, 1);
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic report;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(code_o == 3'd0, "R1 code after reset", code_o, 0);
        chk(!done_o, "R1 done after reset", done_o, 0);
        chk(!timeout_o, "R1 timeout after reset", timeout_o, 0);
        chk(!osc_en_o, "R1 osc_en after reset", osc_en_o, 0);

        run(6, 200, 250, 10, 0, 0, "R2 forced timeout");      // R2 forced code 6
        run(0, 200, 250, 10, 1, 0, "R5 timeout clear");       // R6 rounding gives 5, R9 ignored start
        run(0, 100, 125, 10, 0, 0, "R5 timeout clear");       // R6 code 1, R4
        run(0, 255, 255, 2, 0, 0, "R5 timeout clear");        // R8 saturates at 7
        run(0, 200, 250, 0, 0, 1, "R5 timeout set");          // R5 timeout, R7 zero count
        chk(timeout_o == 1'b1, "R5 timeout flag holds", timeout_o, 1);
        run(0, 200, 250, 10, 0, 0, "R10 timeout cleared");    // R10 cleared by new start
        run(1, 0, 0, 10, 0, 0, "R2 forced timeout");          // R2 forced code 1
        report();
    end

endmodule